// File: doc/BRIEF.md
# Write-Streak Line Migration Controller

This block decides when a line of a hybrid last-level cache should move between its SRAM banks and its STT-RAM banks. The cache reports one access event per cycle: a fill caused by a store miss or a load miss, a read hit, a write hit or an eviction, together with the line index. The controller keeps a small record per line: whether the line is valid, which technology holds it, where an SRAM line came from, and three small counters. From these it raises a one-cycle migration request naming the line and the direction.

Lines that keep being written while in STT-RAM are pulled into SRAM. Two trigger conditions are used: a streak of writes with no read in between, and a running total of writes. Lines in SRAM that are being read go back to STT-RAM. A line that was filled straight from lower memory goes back on its first read hit. A line that was pulled in from STT-RAM must see a second read hit before it goes back. The controller assumes the cache carries out every request it raises, and it updates its own record of the line in the same step.

Top module: `wm_migrate_ctrl`

## Requirements
- R1: After synchronous reset `mig_valid` is low and every line is invalid, so read hits and write hits to any line raise no request until that line is filled.
- R2: Event codes on `ev_kind` are 0 store-miss fill, 1 load-miss fill, 2 read hit, 3 write hit and 4 eviction. A store-miss fill places the line in SRAM and marks it as filled from memory. A load-miss fill places the line in STT-RAM. No fill ever raises a request.
- R3: A write hit to an STT-RAM line that is the second write in a row, with no read between them, raises a request toward SRAM (`mig_to_sram` = 1).
- R4: A read hit to an STT-RAM line breaks the write streak but keeps the running write total. The third write since the line entered STT-RAM raises a request toward SRAM. The total saturates at its maximum and does not wrap.
- R5: A read hit to an SRAM line that was filled from memory raises a request toward STT-RAM (`mig_to_sram` = 0) on the first read hit.
- R6: An SRAM line that entered SRAM by migration from STT-RAM raises its request toward STT-RAM on the second read hit and not on the first.
- R7: Migration and eviction clear all counters of the line. After a return to STT-RAM, the line needs a fresh streak or a fresh total to move to SRAM again.
- R8: Write hits to SRAM lines and any event to an invalid or evicted line change no state and raise no request.
- R9: A request is registered. `mig_valid` is high for exactly the one cycle after the triggering event, and `mig_line` carries that event's line index.
- R10: Codes 5 to 7 on `ev_kind` are ignored, as is any cycle in which `ev_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_valid | input | 1 | An access event is present this cycle |
| ev_kind | input | 3 | Event code (see R2) |
| ev_line | input | LINE_W | Index of the tracked line |
| mig_valid | output | 1 | Migration request, one-cycle pulse |
| mig_line | output | LINE_W | Line to migrate |
| mig_to_sram | output | 1 | 1: STT-RAM to SRAM, 0: SRAM to STT-RAM |

## Verification
Several write patterns are applied to STT-RAM lines: two writes back to back, writes broken up by reads, and three writes spread out. These show apart the streak trigger and the running-total trigger, and confirm that a read clears only the streak. Read hits go to SRAM lines of both origins, which shows apart the active threshold of one hit and the lazy threshold of two. Evictions, unfilled lines, SRAM write hits and undefined codes test the ignore paths. A random mix over a handful of lines, compared against a behavioural model in the bench, covers the orderings that the directed sequences do not.

// File: rtl/wm_mig_pkg.sv
package wm_mig_pkg;

  typedef enum logic [2:0] {
    EV_FILL_STORE = 3'd0,
    EV_FILL_LOAD  = 3'd1,
    EV_READ_HIT   = 3'd2,
    EV_WRITE_HIT  = 3'd3,
    EV_EVICT      = 3'd4
  } ev_kind_e;

endpackage

// File: rtl/wm_line_table.sv
module wm_line_table #(
  parameter int NUM_LINES = 64,
  parameter int ENT_W     = 8,
  localparam int LINE_W   = $clog2(NUM_LINES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [LINE_W-1:0] idx,
  output logic [ENT_W-1:0]  rd_ent,
  output logic              rd_vld,
  input  logic              ent_we,
  input  logic [ENT_W-1:0]  wr_ent,
  input  logic              vld_we,
  input  logic              vld_val
);

  // Entry payload: no reset, plain array that maps to distributed RAM.
  logic [ENT_W-1:0] mem [NUM_LINES];
  logic [NUM_LINES-1:0] vld_q;

  always_ff @(posedge clk) begin
    if (ent_we) mem[idx] <= wr_ent;
  end

  assign rd_ent = mem[idx];
  assign rd_vld = vld_q[idx];

  // Valid bits: one resettable flop per line.
  for (genvar g = 0; g < NUM_LINES; g++) begin : g_vld
    always_ff @(posedge clk) begin
      if (rst)
        vld_q[g] <= 1'b0;
      else if (vld_we && (idx == LINE_W'(g)))
        vld_q[g] <= vld_val;
    end
  end

endmodule

// File: rtl/wm_mig_decide.sv
module wm_mig_decide
  import wm_mig_pkg::*;
#(
  parameter int CNT_W     = 2,
  parameter int STREAK_TH = 2,
  parameter int TOTAL_TH  = 3,
  parameter int ACTIVE_TH = 1,
  parameter int LAZY_TH   = 2,
  localparam int ENT_W    = 2 + 3*CNT_W
) (
  input  logic             ev_valid,
  input  logic [2:0]       ev_kind,
  input  logic             cur_vld,
  input  logic [ENT_W-1:0] cur_ent,
  output logic             ent_we,
  output logic [ENT_W-1:0] nxt_ent,
  output logic             vld_we,
  output logic             vld_val,
  output logic             fire,
  output logic             fire_to_sram
);

  localparam int P_SRAM = ENT_W - 1;
  localparam int P_ORIG = ENT_W - 2;
  localparam logic [CNT_W-1:0] STREAK_L = CNT_W'(STREAK_TH);
  localparam logic [CNT_W-1:0] TOTAL_L  = CNT_W'(TOTAL_TH);
  localparam logic [CNT_W-1:0] ACTIVE_L = CNT_W'(ACTIVE_TH);
  localparam logic [CNT_W-1:0] LAZY_L   = CNT_W'(LAZY_TH);

  function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] v);
    return (v == '1) ? v : v + 1'b1;
  endfunction

  function automatic logic [ENT_W-1:0] pack(input logic sram, input logic orig,
                                            input logic [CNT_W-1:0] s,
                                            input logic [CNT_W-1:0] t,
                                            input logic [CNT_W-1:0] r);
    return {sram, orig, s, t, r};
  endfunction

  logic             in_sram, from_stt;
  logic [CNT_W-1:0] streak, total, reads;
  logic [CNT_W-1:0] streak_n, total_n, reads_n, read_th;

  assign in_sram  = cur_ent[P_SRAM];
  assign from_stt = cur_ent[P_ORIG];
  assign streak   = cur_ent[3*CNT_W-1:2*CNT_W];
  assign total    = cur_ent[2*CNT_W-1:CNT_W];
  assign reads    = cur_ent[CNT_W-1:0];

  assign streak_n = sat_inc(streak);
  assign total_n  = sat_inc(total);
  assign reads_n  = sat_inc(reads);
  assign read_th  = from_stt ? LAZY_L : ACTIVE_L;

  always_comb begin
    ent_we       = 1'b0;
    nxt_ent      = cur_ent;
    vld_we       = 1'b0;
    vld_val      = 1'b0;
    fire         = 1'b0;
    fire_to_sram = 1'b0;
    if (ev_valid) begin
      unique case (ev_kind)
        EV_FILL_STORE: begin
          ent_we  = 1'b1;
          vld_we  = 1'b1;
          vld_val = 1'b1;
          nxt_ent = pack(1'b1, 1'b0, '0, '0, '0);
        end
        EV_FILL_LOAD: begin
          ent_we  = 1'b1;
          vld_we  = 1'b1;
          vld_val = 1'b1;
          nxt_ent = pack(1'b0, 1'b0, '0, '0, '0);
        end
        EV_READ_HIT: begin
          if (cur_vld) begin
            ent_we = 1'b1;
            if (in_sram) begin
              if (reads_n >= read_th) begin
                fire    = 1'b1;
                nxt_ent = pack(1'b0, 1'b0, '0, '0, '0);
              end else begin
                nxt_ent = pack(1'b1, from_stt, streak, total, reads_n);
              end
            end else begin
              nxt_ent = pack(1'b0, from_stt, '0, total, reads);
            end
          end
        end
        EV_WRITE_HIT: begin
          if (cur_vld && !in_sram) begin
            ent_we = 1'b1;
            if ((streak_n >= STREAK_L) || (total_n >= TOTAL_L)) begin
              fire         = 1'b1;
              fire_to_sram = 1'b1;
              nxt_ent      = pack(1'b1, 1'b1, '0, '0, '0);
            end else begin
              nxt_ent = pack(1'b0, from_stt, streak_n, total_n, reads);
            end
          end
        end
        EV_EVICT: begin
          if (cur_vld) begin
            ent_we  = 1'b1;
            vld_we  = 1'b1;
            vld_val = 1'b0;
            nxt_ent = '0;
          end
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/wm_req_reg.sv
module wm_req_reg #(
  parameter int LINE_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fire,
  input  logic              fire_to_sram,
  input  logic [LINE_W-1:0] fire_line,
  output logic              mig_valid,
  output logic [LINE_W-1:0] mig_line,
  output logic              mig_to_sram
);

  always_ff @(posedge clk) begin
    if (rst) begin
      mig_valid   <= 1'b0;
      mig_line    <= '0;
      mig_to_sram <= 1'b0;
    end else begin
      mig_valid   <= fire;
      mig_line    <= fire_line;
      mig_to_sram <= fire_to_sram;
    end
  end

endmodule

// File: rtl/wm_migrate_ctrl.sv
module wm_migrate_ctrl #(
  parameter int NUM_LINES = 64,
  parameter int CNT_W     = 2,
  parameter int STREAK_TH = 2,
  parameter int TOTAL_TH  = 3,
  parameter int ACTIVE_TH = 1,
  parameter int LAZY_TH   = 2,
  localparam int LINE_W   = $clog2(NUM_LINES),
  localparam int ENT_W    = 2 + 3*CNT_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ev_valid,
  input  logic [2:0]        ev_kind,
  input  logic [LINE_W-1:0] ev_line,
  output logic              mig_valid,
  output logic [LINE_W-1:0] mig_line,
  output logic              mig_to_sram
);

  logic [ENT_W-1:0] cur_ent, nxt_ent;
  logic             cur_vld, ent_we, vld_we, vld_val, fire, fire_to_sram;

  wm_line_table #(.NUM_LINES(NUM_LINES), .ENT_W(ENT_W)) u_table (
    .clk    (clk),
    .rst    (rst),
    .idx    (ev_line),
    .rd_ent (cur_ent),
    .rd_vld (cur_vld),
    .ent_we (ent_we),
    .wr_ent (nxt_ent),
    .vld_we (vld_we),
    .vld_val(vld_val)
  );

  wm_mig_decide #(
    .CNT_W(CNT_W), .STREAK_TH(STREAK_TH), .TOTAL_TH(TOTAL_TH),
    .ACTIVE_TH(ACTIVE_TH), .LAZY_TH(LAZY_TH)
  ) u_decide (
    .ev_valid    (ev_valid),
    .ev_kind     (ev_kind),
    .cur_vld     (cur_vld),
    .cur_ent     (cur_ent),
    .ent_we      (ent_we),
    .nxt_ent     (nxt_ent),
    .vld_we      (vld_we),
    .vld_val     (vld_val),
    .fire        (fire),
    .fire_to_sram(fire_to_sram)
  );

  wm_req_reg #(.LINE_W(LINE_W)) u_req (
    .clk         (clk),
    .rst         (rst),
    .fire        (fire),
    .fire_to_sram(fire_to_sram),
    .fire_line   (ev_line),
    .mig_valid   (mig_valid),
    .mig_line    (mig_line),
    .mig_to_sram (mig_to_sram)
  );

endmodule

// File: rtl/wm_migrate_chk.sv
module wm_migrate_chk
  import wm_mig_pkg::*;
#(
  parameter int LINE_W = 6
) (
  input logic              clk,
  input logic              rst,
  input logic              ev_valid,
  input logic [2:0]        ev_kind,
  input logic [LINE_W-1:0] ev_line,
  input logic              mig_valid,
  input logic [LINE_W-1:0] mig_line,
  input logic              mig_to_sram
);

  // R1
  reset_quiet_chk: assert property (@(posedge clk) rst |=> !mig_valid);

  // R9
  req_source_chk: assert property (@(posedge clk) disable iff (rst)
    mig_valid |-> $past(ev_valid) &&
                  ($past(ev_kind) == EV_READ_HIT || $past(ev_kind) == EV_WRITE_HIT));

  // R9
  req_line_chk: assert property (@(posedge clk) disable iff (rst)
    mig_valid |-> mig_line == $past(ev_line));

  // R3
  to_sram_write_chk: assert property (@(posedge clk) disable iff (rst)
    (mig_valid && mig_to_sram) |-> $past(ev_kind) == EV_WRITE_HIT);

  // R5
  to_stt_read_chk: assert property (@(posedge clk) disable iff (rst)
    (mig_valid && !mig_to_sram) |-> $past(ev_kind) == EV_READ_HIT);

  // R2
  fill_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (ev_valid && (ev_kind == EV_FILL_STORE || ev_kind == EV_FILL_LOAD)) |=> !mig_valid);

endmodule

bind wm_migrate_ctrl wm_migrate_chk #(.LINE_W(LINE_W)) u_chk (.*);

// File: tb/sim_wm_migrate_ctrl.sv
`timescale 1ns/1ps
module sim_wm_migrate_ctrl;

  localparam int LINES = 64;
  localparam int LW    = 6;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          ev_valid = 1'b0;
  logic [2:0]    ev_kind = 3'd0;
  logic [LW-1:0] ev_line = '0;
  logic          mig_valid, mig_to_sram;
  logic [LW-1:0] mig_line;

  int n_tests = 0;
  int n_fail  = 0;

  always #2.5 clk = ~clk;

  wm_migrate_ctrl u0 (
    .clk(clk), .rst(rst), .ev_valid(ev_valid), .ev_kind(ev_kind),
    .ev_line(ev_line), .mig_valid(mig_valid), .mig_line(mig_line),
    .mig_to_sram(mig_to_sram)
  );

  // Behavioural model built from the requirements.
  bit m_vld [LINES];
  bit m_sram[LINES];
  bit m_orig[LINES];
  int m_s   [LINES];
  int m_t   [LINES];
  int m_r   [LINES];

  function automatic int sat3(input int v);
    return (v >= 3) ? 3 : v;
  endfunction

  function automatic void clear_cnt(input int ln);
    m_s[ln] = 0; m_t[ln] = 0; m_r[ln] = 0;
  endfunction

  function automatic void model(input int k, input int ln,
                                output bit f, output bit dir);
    f = 0; dir = 0;
    case (k)
      0: begin m_vld[ln] = 1; m_sram[ln] = 1; m_orig[ln] = 0; clear_cnt(ln); end
      1: begin m_vld[ln] = 1; m_sram[ln] = 0; m_orig[ln] = 0; clear_cnt(ln); end
      2: if (m_vld[ln]) begin
           if (m_sram[ln]) begin
             m_r[ln] = sat3(m_r[ln] + 1);
             if (m_r[ln] >= (m_orig[ln] ? 2 : 1)) begin
               f = 1; dir = 0;
               m_sram[ln] = 0; m_orig[ln] = 0; clear_cnt(ln);
             end
           end else m_s[ln] = 0;
         end
      3: if (m_vld[ln] && !m_sram[ln]) begin
           m_s[ln] = sat3(m_s[ln] + 1);
           m_t[ln] = sat3(m_t[ln] + 1);
           if (m_s[ln] >= 2 || m_t[ln] >= 3) begin
             f = 1; dir = 1;
             m_sram[ln] = 1; m_orig[ln] = 1; clear_cnt(ln);
           end
         end
      4: if (m_vld[ln]) begin m_vld[ln] = 0; clear_cnt(ln); end
      default: ;
    endcase
  endfunction

  task automatic check_out(input string tag, input bit ev, input bit ed, input int ln);
    n_tests++;
    if (mig_valid !== ev || (ev && (mig_to_sram !== ed || mig_line !== LW'(ln)))) begin
      n_fail++;
      $display("FAIL %s: valid=%0b dir=%0b line=%0d expected valid=%0b dir=%0b line=%0d",
               tag, mig_valid, mig_to_sram, mig_line, ev, ed, ln);
    end
  endtask

  // Called at a falling edge; returns at the next falling edge after checking.
  task automatic ev_step(input int k, input int ln, input string tag);
    bit f, d;
    model(k, ln, f, d);
    ev_valid = 1'b1; ev_kind = k[2:0]; ev_line = LW'(ln);
    @(negedge clk);
    ev_valid = 1'b0;
    check_out(tag, f, d, ln);
  endtask

  task automatic idle_step(input string tag);
    ev_valid = 1'b0;
    @(negedge clk);
    check_out(tag, 1'b0, 1'b0, 0);
  endtask

  initial begin
    #(200000 * 5.0);
    n_fail++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < LINES; i++) begin
      m_vld[i] = 0; m_sram[i] = 0; m_orig[i] = 0; clear_cnt(i);
    end
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check_out("R1 reset output", 1'b0, 1'b0, 0);

    // R1 / R8: hits to unfilled lines
    ev_step(2, 3, "R1 read on unfilled line");
    ev_step(3, 3, "R1 write on unfilled line");
    // R2 / R3: load fill then write streak
    ev_step(1, 5, "R2 load fill quiet");
    ev_step(3, 5, "R3 first write");
    ev_step(3, 5, "R3 second write migrates");
    idle_step("R9 request is a single pulse");
    // R6: lazy return
    ev_step(2, 5, "R6 first read stays");
    ev_step(2, 5, "R6 second read returns");
    // R7 / R4: fresh counters, streak broken by reads, total triggers
    ev_step(3, 5, "R7 write after return");
    ev_step(2, 5, "R4 read breaks streak");
    ev_step(3, 5, "R4 second total write");
    ev_step(2, 5, "R4 read breaks streak again");
    ev_step(3, 5, "R4 third total write migrates");
    // R5: active return
    ev_step(0, 9, "R2 store fill quiet");
    ev_step(2, 9, "R5 first read returns");
    // R8: SRAM write hit, evicted line
    ev_step(0, 10, "R2 store fill");
    ev_step(3, 10, "R8 write to SRAM line");
    ev_step(4, 10, "R8 evict");
    ev_step(2, 10, "R8 read after evict");
    // R10: undefined codes and idle cycles
    ev_step(1, 12, "R2 load fill");
    ev_step(3, 12, "R10 first write");
    ev_step(6, 12, "R10 undefined code");
    idle_step("R10 idle cycle");
    ev_step(3, 12, "R10 streak survives undefined code");
    // R9 back-to-back requests on two lines
    ev_step(0, 20, "R2 store fill");
    ev_step(0, 21, "R2 store fill");
    ev_step(2, 20, "R9 back to back first");
    ev_step(2, 21, "R9 back to back second");

    // Random mix
    for (int n = 0; n < 3000; n++) begin
      int sel, k, ln;
      sel = int'($urandom % 10);
      ln  = int'($urandom % 6);
      case (sel)
        0: k = 0;
        1: k = 1;
        2, 3, 4: k = 2;
        5, 6, 7: k = 3;
        8: k = 4;
        default: k = 5 + int'($urandom % 3);
      endcase
      if ($urandom % 8 == 0) idle_step("R10 random idle");
      ev_step(k, ln, "R9 random mix");
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule